// File: doc/BRIEF.md
# Byte-Lane Data Memory With Access Size Selection

This block is a byte-organised storage array behind a 32-bit data port. A two-bit size selector picks one of four access widths for the current cycle: disabled, one byte, two bytes or four bytes. The same width applies to the combinational read port and to the write that is stored on the chosen clock edge. Multi-byte accesses are little-endian. The lowest-addressed byte sits in bits 7:0 of the word. Lanes outside the selected width read as zero and are never written.

Only as many low address bits as the byte capacity needs are decoded, and any higher bits are ignored. If an access runs past the last byte, it wraps around to the start of the array. Reset loads every byte with a configurable fill value. Parameters set the storing edge (rising or falling) and the active level of reset and of write enable. A read-only parameter turns the block into an instruction store: writes are disabled and the width is fixed at four bytes, whatever the select input says.

Top module: `bytelane_dmem`

## Requirements
- R1: While reset is active at the storing edge, every byte is loaded with FILL_BYTE (default 8'hA5), so a four-byte read after reset returns 32'hA5A5A5A5.
- R2: Size code 0 (disabled) makes rdata 32'h0 and suppresses any write, even with write enable active.
- R3: Size code 1 (byte) stores only wdata[7:0] at the addressed byte and reads that byte into rdata[7:0] with rdata[31:8] zero.
- R4: Size code 2 (half word) stores wdata[7:0] at address A and wdata[15:8] at A+1, and reads them back the same way with rdata[31:16] zero.
- R5: Size code 3 (word) stores wdata[8k+7:8k] at byte A+k for k = 0..3, and reads them back the same way (little-endian).
- R6: Only the low B address bits are decoded, where B = ceil(log2(CAPACITY)) and B = 1 when CAPACITY is 1 (B = 6 at the default of 64). Higher address bits have no effect.
- R7: Byte A+k of a multi-byte access is location ((A mod 2^B) + k) mod CAPACITY, so accesses past the top wrap to location 0.
- R8: A write happens only when write enable is at its active level at the storing edge. The read port is combinational, so the new data is visible right after that edge.
- R9: With READ_ONLY set, write enable and write data have no effect, and the size input is treated as code 3.
- R10: NEG_EDGE selects the falling clock edge for storing. RST_ACTIVE_HIGH = 0 and WE_ACTIVE_HIGH = 0 make reset and write enable active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the storing edge is set by NEG_EDGE |
| rst | input | 1 | Synchronous fill reset, level set by RST_ACTIVE_HIGH |
| addr | input | ADDR_IN_W | Byte address; only the low B bits are decoded |
| wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| wr_en | input | 1 | Write enable, level set by WE_ACTIVE_HIGH |
| mode | input | 2 | Access size: 0 off, 1 byte, 2 half word, 3 word |
| rdata | output | 32 | Combinational read data, unused lanes zero |

## Verification
The bench targets the following corner cases:
- **Lane handling in narrow modes.** Byte and half-word accesses are checked against neighbouring bytes that still hold the fill value. A design that ignored the mask would overwrite those bytes or leak them into the upper read lanes.
- **Disabled mode.** A write is attempted with size code 0. A design that decoded code 0 as a width would change memory or return non-zero data.
- **Ignored high address bits.** An address with all high bits set is used. A design that decoded those bits would miss the intended location.
- **Wrap-around.** Word accesses start at the last locations of a power-of-two array and of a six-byte array. The six-byte case shows whether the wrap is modulo the capacity rather than modulo the power of two.
- **Variants.** A read-only instance and a falling-edge, active-low instance receive the same stimulus. They catch a variant that still writes, or one that stores on the wrong edge or at the wrong level.

// File: rtl/bytelane_dmem_pkg.sv
package bytelane_dmem_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        ACC_OFF  = 2'd0,
        ACC_BYTE = 2'd1,
        ACC_HALF = 2'd2,
        ACC_WORD = 2'd3
    } acc_mode_e;

    // Number of decoded address bits for a given byte capacity.
    function automatic int idx_bits(int cap);
        if (cap < 2) begin
            return 1;
        end
        return $clog2(cap);
    endfunction

    // Lanes taking part in an access of the given size.
    function automatic logic [LANES-1:0] lane_mask(acc_mode_e m);
        logic [LANES-1:0] r;
        case (m)
            ACC_BYTE: r = 4'b0001;
            ACC_HALF: r = 4'b0011;
            ACC_WORD: r = 4'b1111;
            default:  r = 4'b0000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bytelane_dmem_map.sv
module bytelane_dmem_map
    import bytelane_dmem_pkg::*;
#(
    parameter int CAPACITY = 64,
    parameter int IDXW     = 6
) (
    input  logic [IDXW-1:0]             base_addr,
    input  acc_mode_e                   acc_mode,
    output logic [LANES-1:0]            lane_en,
    output logic [LANES-1:0][IDXW-1:0]  lane_idx
);

    localparam int SW = IDXW + 3;

    assign lane_en = lane_mask(acc_mode);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SW-1:0] raw_pos;
        logic [SW-1:0] wrapped;
        always_comb begin
            raw_pos = SW'(base_addr) + SW'(k);
            wrapped = raw_pos % SW'(CAPACITY);
        end
        assign lane_idx[k] = wrapped[IDXW-1:0];
    end

endmodule

// File: rtl/bytelane_dmem_store.sv
module bytelane_dmem_store
    import bytelane_dmem_pkg::*;
#(
    parameter int          CAPACITY  = 64,
    parameter int          IDXW      = 6,
    parameter logic [7:0]  FILL_BYTE = 8'hA5,
    parameter bit          NEG_EDGE  = 1'b0
) (
    input  logic                            clk,
    input  logic                            fill_req,
    input  logic                            store_req,
    input  logic [LANES-1:0]                lane_en,
    input  logic [LANES-1:0][IDXW-1:0]      lane_idx,
    input  logic [WORD_W-1:0]               wr_word,
    output logic [CAPACITY-1:0][BYTE_W-1:0] cells
);

    typedef struct packed {
        logic [CAPACITY-1:0][BYTE_W-1:0] cells;
    } store_t;

    store_t store_d;
    store_t store_q;

    always_comb begin
        store_d = store_q;
        if (fill_req) begin
            for (int i = 0; i < CAPACITY; i++) begin
                store_d.cells[i] = FILL_BYTE;
            end
        end else if (store_req) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_en[k]) begin
                    store_d.cells[lane_idx[k]] = wr_word[BYTE_W*k +: BYTE_W];
                end
            end
        end
    end

    if (NEG_EDGE) begin : g_fall
        always_ff @(negedge clk) begin
            store_q <= store_d;
        end
    end else begin : g_rise
        always_ff @(posedge clk) begin
            store_q <= store_d;
        end
    end

    assign cells = store_q.cells;

endmodule

// File: rtl/bytelane_dmem_rdmux.sv
module bytelane_dmem_rdmux
    import bytelane_dmem_pkg::*;
#(
    parameter int CAPACITY = 64,
    parameter int IDXW     = 6
) (
    input  logic [CAPACITY-1:0][BYTE_W-1:0] cells,
    input  logic [LANES-1:0]                lane_en,
    input  logic [LANES-1:0][IDXW-1:0]      lane_idx,
    output logic [WORD_W-1:0]               rd_word
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd_word[BYTE_W*k +: BYTE_W] = lane_en[k] ? cells[lane_idx[k]] : '0;
    end

endmodule

// File: rtl/bytelane_dmem.sv
module bytelane_dmem
    import bytelane_dmem_pkg::*;
#(
    parameter int          CAPACITY        = 64,
    parameter int          ADDR_IN_W       = 32,
    parameter logic [7:0]  FILL_BYTE       = 8'hA5,
    parameter bit          NEG_EDGE        = 1'b0,
    parameter bit          RST_ACTIVE_HIGH = 1'b1,
    parameter bit          WE_ACTIVE_HIGH  = 1'b1,
    parameter bit          READ_ONLY       = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_IN_W-1:0] addr,
    input  logic [31:0]          wdata,
    input  logic                 wr_en,
    input  logic [1:0]           mode,
    output logic [31:0]          rdata
);

    localparam int IDXW = idx_bits(CAPACITY);

    logic                            fill_req;
    logic                            store_req;
    acc_mode_e                       eff_mode;
    logic [IDXW-1:0]                 base_addr;
    logic [LANES-1:0]                lane_en;
    logic [LANES-1:0][IDXW-1:0]      lane_idx;
    logic [CAPACITY-1:0][BYTE_W-1:0] cells_w;
    logic                            unused_addr_par;

    // Polarity decode; the read-only variant forces word access, no stores.
    assign fill_req  = RST_ACTIVE_HIGH ? rst : ~rst;
    assign store_req = (WE_ACTIVE_HIGH ? wr_en : ~wr_en) & ~READ_ONLY;
    assign eff_mode  = READ_ONLY ? ACC_WORD : acc_mode_e'(mode);
    assign base_addr = addr[IDXW-1:0];
    assign unused_addr_par = ^addr;

    bytelane_dmem_map #(
        .CAPACITY (CAPACITY),
        .IDXW     (IDXW)
    ) u_map (
        .base_addr (base_addr),
        .acc_mode  (eff_mode),
        .lane_en   (lane_en),
        .lane_idx  (lane_idx)
    );

    bytelane_dmem_store #(
        .CAPACITY  (CAPACITY),
        .IDXW      (IDXW),
        .FILL_BYTE (FILL_BYTE),
        .NEG_EDGE  (NEG_EDGE)
    ) u_store (
        .clk       (clk),
        .fill_req  (fill_req),
        .store_req (store_req),
        .lane_en   (lane_en),
        .lane_idx  (lane_idx),
        .wr_word   (wdata),
        .cells     (cells_w)
    );

    bytelane_dmem_rdmux #(
        .CAPACITY (CAPACITY),
        .IDXW     (IDXW)
    ) u_rdmux (
        .cells    (cells_w),
        .lane_en  (lane_en),
        .lane_idx (lane_idx),
        .rd_word  (rdata)
    );

endmodule

// File: rtl/bytelane_dmem_chk.sv
module bytelane_dmem_chk #(
    parameter int          CAPACITY        = 64,
    parameter logic [7:0]  FILL_BYTE       = 8'hA5,
    parameter bit          NEG_EDGE        = 1'b0,
    parameter bit          RST_ACTIVE_HIGH = 1'b1,
    parameter bit          WE_ACTIVE_HIGH  = 1'b1,
    parameter bit          READ_ONLY       = 1'b0
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [1:0]              mode,
    input logic [31:0]             rdata,
    input logic [CAPACITY-1:0][7:0] cells
);

    logic ck;
    logic rst_act;
    logic we_act;

    assign ck      = NEG_EDGE ? ~clk : clk;
    assign rst_act = RST_ACTIVE_HIGH ? rst : ~rst;
    assign we_act  = WE_ACTIVE_HIGH ? wr_en : ~wr_en;

    // R1: leaving reset, the whole array holds the fill byte
    assert_reset_fill_R1: assert property (@(posedge ck) disable iff (rst_act)
        $fell(rst_act) |-> (cells == {CAPACITY{FILL_BYTE}}));

    // R8: no store when write enable is inactive
    assert_idle_hold_R8: assert property (@(posedge ck) disable iff (rst_act)
        !we_act |=> $stable(cells));

    if (READ_ONLY) begin : g_ro
        // R9: a read-only instance never changes its contents
        assert_ro_hold_R9: assert property (@(posedge ck) disable iff (rst_act)
            we_act |=> $stable(cells));
    end else begin : g_rw
        // R2: disabled size reads zero and stores nothing
        assert_off_zero_R2: assert property (@(posedge ck) disable iff (rst_act)
            (mode == 2'd0) |-> (rdata == 32'h0));
        assert_off_hold_R2: assert property (@(posedge ck) disable iff (rst_act)
            (mode == 2'd0) |=> $stable(cells));
        // R3: byte reads leave upper lanes zero
        assert_byte_upper_R3: assert property (@(posedge ck) disable iff (rst_act)
            (mode == 2'd1) |-> (rdata[31:8] == 24'h0));
        // R4: half-word reads leave upper lanes zero
        assert_half_upper_R4: assert property (@(posedge ck) disable iff (rst_act)
            (mode == 2'd2) |-> (rdata[31:16] == 16'h0));
    end

endmodule

bind bytelane_dmem bytelane_dmem_chk #(
    .CAPACITY        (CAPACITY),
    .FILL_BYTE       (FILL_BYTE),
    .NEG_EDGE        (NEG_EDGE),
    .RST_ACTIVE_HIGH (RST_ACTIVE_HIGH),
    .WE_ACTIVE_HIGH  (WE_ACTIVE_HIGH),
    .READ_ONLY       (READ_ONLY)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .mode  (mode),
    .rdata (rdata),
    .cells (cells_w)
);

// File: tb/bytelane_dmem_bench.sv
`timescale 1ns/1ps
module bytelane_dmem_bench;

    localparam logic [7:0]  FILL  = 8'hA5;
    localparam logic [31:0] FILLW = {4{FILL}};
    localparam int MCAP = 64;
    localparam int ACAP = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [1:0]  mode = 2'd3;
    logic [31:0] rd_main;
    logic [31:0] rd_alt;
    logic [31:0] rd_ro;
    logic        alt_rst_n;
    logic        alt_we_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mm [MCAP];
    logic [7:0] am [ACAP];

    always #2 clk = ~clk;

    assign alt_rst_n = ~rst;
    assign alt_we_n  = ~we;

    bytelane_dmem #(.CAPACITY(MCAP)) u_bytelane_dmem (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(we), .mode(mode), .rdata(rd_main));

    bytelane_dmem #(.CAPACITY(ACAP), .NEG_EDGE(1'b1), .RST_ACTIVE_HIGH(1'b0),
                    .WE_ACTIVE_HIGH(1'b0)) u_bytelane_dmem_alt (
        .clk(clk), .rst(alt_rst_n), .addr(addr), .wdata(wdata),
        .wr_en(alt_we_n), .mode(mode), .rdata(rd_alt));

    bytelane_dmem #(.CAPACITY(MCAP), .READ_ONLY(1'b1)) u_bytelane_dmem_ro (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(we), .mode(mode), .rdata(rd_ro));

    function automatic int nbytes(logic [1:0] m);
        case (m)
            2'd1: return 1;
            2'd2: return 2;
            2'd3: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int midx(logic [31:0] a, int k);
        return (int'(a[5:0]) + k) % MCAP;
    endfunction

    function automatic int aidx(logic [31:0] a, int k);
        return (int'(a[2:0]) + k) % ACAP;
    endfunction

    function automatic logic [31:0] mread(logic [31:0] a, logic [1:0] m);
        logic [31:0] r = '0;
        for (int k = 0; k < nbytes(m); k++) r[8*k +: 8] = mm[midx(a, k)];
        return r;
    endfunction

    function automatic logic [31:0] aread(logic [31:0] a, logic [1:0] m);
        logic [31:0] r = '0;
        for (int k = 0; k < nbytes(m); k++) r[8*k +: 8] = am[aidx(a, k)];
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(logic [31:0] a, logic [31:0] d, logic [1:0] m, logic en);
        @(posedge clk); #0.5;
        addr = a; wdata = d; mode = m; we = en;
        @(posedge clk); #0.5;
        we = 1'b0;
        if (en) begin
            for (int k = 0; k < nbytes(m); k++) begin
                mm[midx(a, k)] = d[8*k +: 8];
                am[aidx(a, k)] = d[8*k +: 8];
            end
        end
    endtask

    task automatic read_all(string tag, logic [31:0] a, logic [1:0] m);
        @(posedge clk); #0.5;
        addr = a; mode = m;
        #1;
        chk({tag, " main"}, rd_main, mread(a, m));
        chk({tag, " alt R10"}, rd_alt, aread(a, m));
        chk({tag, " ro R9"}, rd_ro, FILLW);
    endtask

    task automatic t_reset_R1();
        read_all("R1 reset word@0", 32'd0, 2'd3);
        read_all("R1 reset word@60", 32'd60, 2'd3);
        chk("R1 literal main", rd_main, FILLW);
        chk("R1 literal alt", rd_alt, FILLW);
    endtask

    task automatic t_word_R5();
        do_write(32'd8, 32'h11223344, 2'd3, 1'b1);
        read_all("R5 word@8", 32'd8, 2'd3);
        chk("R5 literal", rd_main, 32'h11223344);
        read_all("R5 byte@11", 32'd11, 2'd1);
        chk("R5 msb at A+3", rd_main, 32'h00000011);
        read_all("R5 half@9", 32'd9, 2'd2);
        chk("R5 half mid", rd_main, 32'h00002233);
    endtask

    task automatic t_byte_R3();
        do_write(32'd20, 32'hDEADBEEF, 2'd1, 1'b1);
        read_all("R3 word@20", 32'd20, 2'd3);
        chk("R3 only low byte stored", rd_main, {FILL, FILL, FILL, 8'hEF});
        read_all("R3 byte@20", 32'd20, 2'd1);
        chk("R3 byte read", rd_main, 32'h000000EF);
    endtask

    task automatic t_half_R4();
        do_write(32'd30, 32'hCAFE1234, 2'd2, 1'b1);
        read_all("R4 word@30", 32'd30, 2'd3);
        chk("R4 two bytes stored", rd_main, {FILL, FILL, 8'h12, 8'h34});
        read_all("R4 half@30", 32'd30, 2'd2);
        chk("R4 half read", rd_main, 32'h00001234);
    endtask

    task automatic t_off_R2();
        do_write(32'd8, 32'h0BADF00D, 2'd0, 1'b1);
        read_all("R2 off read", 32'd8, 2'd0);
        chk("R2 zero", rd_main, 32'h0);
        read_all("R2 word kept", 32'd8, 2'd3);
        chk("R2 no write", rd_main, 32'h11223344);
    endtask

    task automatic t_we_R8();
        do_write(32'd40, 32'h55667788, 2'd3, 1'b0);
        read_all("R8 we low", 32'd40, 2'd3);
        chk("R8 unchanged", rd_main, FILLW);
        do_write(32'd40, 32'h99AABBCC, 2'd3, 1'b1);
        #0.5;
        addr = 32'd40; mode = 2'd3;
        #0.5;
        chk("R8 visible after edge", rd_main, 32'h99AABBCC);
    endtask

    task automatic t_upper_R6();
        do_write(32'hFFFF_FFC4, 32'h0102A3B4, 2'd3, 1'b1);
        read_all("R6 read plain@4", 32'd4, 2'd3);
        chk("R6 literal", rd_main, 32'h0102A3B4);
        read_all("R6 read alias@0x84", 32'h0000_0084, 2'd3);
    endtask

    task automatic t_wrap_R7();
        do_write(32'd62, 32'hF1E2D3C4, 2'd3, 1'b1);
        read_all("R7 half@0", 32'd0, 2'd2);
        chk("R7 wrapped bytes", rd_main, 32'h0000F1E2);
        read_all("R7 word@62", 32'd62, 2'd3);
        do_write(32'd5, 32'h76543210, 2'd3, 1'b1);
        read_all("R7 alt word@5", 32'd5, 2'd3);
        chk("R7 alt wrap", rd_alt, 32'h76543210);
        read_all("R7 alt byte@7", 32'd7, 2'd1);
        chk("R7 alt 7 maps to 1", rd_alt, 32'h00000054);
    endtask

    task automatic t_ro_R9();
        do_write(32'd0, 32'h12345678, 2'd1, 1'b1);
        read_all("R9 ro byte mode", 32'd0, 2'd1);
        chk("R9 ro forced word", rd_ro, FILLW);
    endtask

    task automatic t_alt_R10();
        do_write(32'd8, 32'hA1B2C3D4, 2'd3, 1'b1);
        read_all("R10 alt@8", 32'd8, 2'd3);
        chk("R10 alt literal", rd_alt, 32'hA1B2C3D4);
        do_write(32'd8, 32'h0, 2'd3, 1'b0);
        read_all("R10 alt we inactive", 32'd8, 2'd3);
        chk("R10 alt kept", rd_alt, 32'hA1B2C3D4);
    endtask

    initial begin
        for (int i = 0; i < MCAP; i++) mm[i] = FILL;
        for (int i = 0; i < ACAP; i++) am[i] = FILL;
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        t_reset_R1();
        t_word_R5();
        t_byte_R3();
        t_half_R4();
        t_off_R2();
        t_we_R8();
        t_upper_R6();
        t_wrap_R7();
        t_ro_R9();
        t_alt_R10();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule